// File: doc/BRIEF.md
# Hierarchical Static Test-Control Segment with Child Bypass

This block is one level of a serial static test-control chain, placed in the test wrapper of a core. A serial stream enters on `sdi` and leaves on `sdo`. Along the way it passes through a local field of the segment: one enable bit and a mode code for the local core. When the committed enable is 0, the segment's output comes straight from its local field and the child segments are skipped. When it is 1, a chain of child segments is spliced in after the local field, so the path seen from outside grows longer.

Each register has two stages. While `shift_upd` is high, data moves one bit per clock through the shift stages. A clock with `shift_upd` low copies every shift stage into its update stage. The decoded mode outputs and the enable change only at that point. The enable therefore travels in the same stream as the mode data, and the bit positions of a child depend on the enable committed upstream of it. If every enable is set to 1, the hierarchy becomes one flat chain.

Top module: `tstctl_segment`

## Requirements
- R1: A synchronous active-high reset sets the local mode and every child mode to functional (`5'b00001`) and clears the enable to 0. It also clears all shift stages, so `sdo` reads 0 after reset.
- R2: With the enable at 0 and `shift_upd` high, the path has `1+MODE_W` bits (4 by default). A bit presented on `sdi` appears on `sdo` after exactly that many shift clocks.
- R3: While `shift_upd` is high, `local_mode_o`, `child_en_o` and `child_mode_o` do not change.
- R4: The enable and the mode outputs change only on a clock with `shift_upd` low. That clock copies the shift stages into the update stages.
- R5: The local field is shifted in mode bit 0 first, then mode bits 1 and 2, then the enable bit last. The mode code decodes into one-hot outputs as follows: bit 0 = functional (code 0), bit 1 = scan (1), bit 2 = interconnect (2), bit 3 = safe (3), bit 4 = IDDQ (4). Codes 5 to 7 decode to safe.
- R6: With the enable at 1, the path has `1+MODE_W+N_CHILD*MODE_W` bits (16 by default). A bit on `sdi` appears on `sdo` after exactly that many shift clocks.
- R7: While the enable is 0, shifting and updating leave every child mode output unchanged.
- R8: With the enable at 1, one pass of the full length programs every child and the local field. The stream runs child `N_CHILD-1` first, down to child 0, then the local mode bits, then the enable, each code bit 0 first. Child k is reported on `child_mode_o[5k+4:5k]`.
- R9: Every mode output, local and per child, is one-hot in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_upd | input | 1 | 1: shift one bit per clock; 0: commit the shift stages to the update stages |
| sdi | input | 1 | Serial control data in |
| sdo | output | 1 | Serial control data out, from the local field or from the last child |
| local_mode_o | output | 5 | One-hot static mode of the local core |
| child_en_o | output | 1 | Committed enable; 1 splices the child chain into the path |
| child_mode_o | output | 5*N_CHILD | One-hot static modes of the child segments |

## Verification
On every cycle the assertions check four things: the one-hot form of every mode output, the freezing of all outputs while shifting, that the enable moves only on a commit clock, and that child modes are frozen while the children are bypassed. Some behaviour is visible only in the bench's scenarios. This covers the path length in each enable state, found by shifting a pattern twice and watching the first copy emerge. It also covers the full decode table, including the codes that fall back to safe, and the ordering of child fields in a flattened pass. The bench also checks that stray bits shifted while bypassed never reach the children.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int MODE_KINDS = 5;

  typedef logic [MODE_KINDS-1:0] mode_oh_t;

  typedef enum logic [2:0] {
    MODE_FUNC  = 3'd0,
    MODE_SCAN  = 3'd1,
    MODE_INTC  = 3'd2,
    MODE_SAFE  = 3'd3,
    MODE_IDDQ  = 3'd4
  } mode_code_e;

  localparam mode_oh_t OH_FUNC = 5'b00001;
  localparam mode_oh_t OH_SAFE = 5'b01000;

  function automatic mode_oh_t decode_mode(input logic [31:0] code);
    mode_oh_t r;
    if (code < MODE_KINDS) r = mode_oh_t'(5'b00001 << code[2:0]);
    else                   r = OH_SAFE;
    return r;
  endfunction
endpackage

// File: rtl/tsc_mode_cell.sv
module tsc_mode_cell
  import tsc_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     shift_en,
  input  logic     upd_en,
  input  logic     si,
  output logic     so,
  output mode_oh_t mode_o
);
  logic [MODE_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      mode_o <= OH_FUNC;
    end else if (shift_en) begin
      sr_q <= {si, sr_q[MODE_W-1:1]};
    end else if (upd_en) begin
      mode_o <= decode_mode(32'(sr_q));
    end
  end

  assign so = sr_q[0];
endmodule

// File: rtl/tsc_child_chain.sv
module tsc_child_chain
  import tsc_pkg::*;
#(
  parameter int N_CHILD = 4,
  parameter int MODE_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        shift_en,
  input  logic                        upd_en,
  input  logic                        si,
  output logic                        so,
  output logic [N_CHILD*MODE_KINDS-1:0] modes_o
);
  logic [N_CHILD:0] link;
  assign link[0] = si;

  for (genvar k = 0; k < N_CHILD; k++) begin : g_child
    tsc_mode_cell #(.MODE_W(MODE_W)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .upd_en   (upd_en),
      .si       (link[k]),
      .so       (link[k+1]),
      .mode_o   (modes_o[k*MODE_KINDS +: MODE_KINDS])
    );
  end

  assign so = link[N_CHILD];
endmodule

// File: rtl/tstctl_segment.sv
module tstctl_segment
  import tsc_pkg::*;
#(
  parameter int N_CHILD = 4,
  parameter int MODE_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          shift_upd,
  input  logic                          sdi,
  output logic                          sdo,
  output logic [MODE_KINDS-1:0]         local_mode_o,
  output logic                          child_en_o,
  output logic [N_CHILD*MODE_KINDS-1:0] child_mode_o
);
  logic en_sr_q;
  logic local_so;
  logic chain_so;
  logic child_shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_sr_q    <= 1'b0;
      child_en_o <= 1'b0;
    end else if (shift_upd) begin
      en_sr_q <= sdi;
    end else begin
      child_en_o <= en_sr_q;
    end
  end

  tsc_mode_cell #(.MODE_W(MODE_W)) u_local (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_upd),
    .upd_en   (~shift_upd),
    .si       (en_sr_q),
    .so       (local_so),
    .mode_o   (local_mode_o)
  );

  assign child_shift = shift_upd & child_en_o;

  tsc_child_chain #(.N_CHILD(N_CHILD), .MODE_W(MODE_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (child_shift),
    .upd_en   (~shift_upd),
    .si       (local_so),
    .so       (chain_so),
    .modes_o  (child_mode_o)
  );

  assign sdo = child_en_o ? chain_so : local_so;
endmodule

// File: rtl/tsc_segment_chk.sv
module tsc_segment_chk #(
  parameter int N_CHILD = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   shift_upd,
  input logic [4:0]             local_mode_o,
  input logic                   child_en_o,
  input logic [N_CHILD*5-1:0]   child_mode_o
);
  p_local_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot(local_mode_o));

  for (genvar g = 0; g < N_CHILD; g++) begin : g_oh
    p_child_onehot_r9: assert property (@(posedge clk) disable iff (rst)
      $onehot(child_mode_o[g*5 +: 5]));
  end

  p_hold_while_shift_r3: assert property (@(posedge clk) disable iff (rst)
    shift_upd |=> ($stable(local_mode_o) && $stable(child_en_o) && $stable(child_mode_o)));

  p_en_moves_on_commit_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(child_en_o) |-> !$past(shift_upd));

  p_child_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    !child_en_o |=> $stable(child_mode_o));
endmodule

bind tstctl_segment tsc_segment_chk #(.N_CHILD(N_CHILD)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .shift_upd    (shift_upd),
  .local_mode_o (local_mode_o),
  .child_en_o   (child_en_o),
  .child_mode_o (child_mode_o)
);

// File: tb/sim_tstctl_segment.sv
module sim_tstctl_segment;
  localparam int N  = 4;
  localparam int MW = 3;
  localparam int LB = 1 + MW;
  localparam int LF = 1 + MW + N * MW;
  // {code[2:0], expected one-hot[4:0]}
  localparam logic [7:0] VEC [0:7] = '{8'h01, 8'h22, 8'h44, 8'h68,
                                       8'h90, 8'hA8, 8'hC8, 8'hE8};

  logic clk = 0, rst = 1, shift_upd = 0, sdi = 0;
  logic sdo, child_en_o;
  logic [4:0] local_mode_o;
  logic [N*5-1:0] child_mode_o;
  int checks = 0, errors = 0;
  logic [63:0] seq;
  int n = 0;

  tstctl_segment #(.N_CHILD(N), .MODE_W(MW)) u0 (
    .clk(clk), .rst(rst), .shift_upd(shift_upd), .sdi(sdi), .sdo(sdo),
    .local_mode_o(local_mode_o), .child_en_o(child_en_o), .child_mode_o(child_mode_o));

  always #4 clk = ~clk;

  function automatic logic [4:0] oh(input int code);
    return (code < 5) ? 5'(1 << code) : 5'b01000;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int val, input int w);
    for (int b = 0; b < w; b++) begin seq[n] = val[b]; n++; end
  endtask

  // shifts seq[0..n-1]; if cmp, checks sdo before each shift against prev
  task automatic run_seq(input bit cmp, input logic [63:0] prev, input string req);
    logic [4:0] lm0; logic [N*5-1:0] cm0; logic e0;
    @(negedge clk);
    lm0 = local_mode_o; cm0 = child_mode_o; e0 = child_en_o;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (cmp) chk(sdo == prev[j], req, sdo, prev[j]);
      sdi = seq[j]; shift_upd = 1;
      @(posedge clk);
    end
    @(negedge clk);
    shift_upd = 0;
    chk({lm0, cm0, e0} == {local_mode_o, child_mode_o, child_en_o}, "R3 hold", 0, 1);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input string req);
    @(negedge clk); rst = 1; shift_upd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk(local_mode_o == 5'b00001, req, local_mode_o, 1);
    chk(child_en_o == 0, req, child_en_o, 0);
    chk(sdo == 0, req, sdo, 0);
    for (int k = 0; k < N; k++)
      chk(child_mode_o[k*5 +: 5] == 5'b00001, req, child_mode_o[k*5 +: 5], 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] p;
    int ccode [N];
    ccode[0] = 1; ccode[1] = 0; ccode[2] = 4; ccode[3] = 2;
    do_reset("R1 reset");

    // R5 decode table, bypass mode
    for (int v = 0; v < 8; v++) begin
      n = 0; push(int'(VEC[v][7:5]), MW); push(0, 1);
      run_seq(0, 0, "R5");
      chk(local_mode_o == VEC[v][4:0], "R5 decode", local_mode_o, VEC[v][4:0]);
      chk(local_mode_o == oh(v), "R5 decode ref", local_mode_o, oh(v));
      chk(child_en_o == 0, "R4 enable stays 0", child_en_o, 0);
    end

    // R2 bypass length: shift pattern twice
    n = 0; push(3, MW); push(0, 1); p = seq;   // mode safe, en 0
    run_seq(0, 0, "R2");
    run_seq(1, p, "R2 bypass length");

    // enable children (local code 1, en 1)
    n = 0; push(1, MW); push(1, 1);
    run_seq(0, 0, "R4");
    chk(child_en_o == 1, "R4 enable commit", child_en_o, 1);
    chk(local_mode_o == 5'b00010, "R4 local commit", local_mode_o, 2);

    // R8 flatten: program all children
    n = 0;
    for (int k = N - 1; k >= 0; k--) push(ccode[k], MW);
    push(2, MW); push(1, 1); p = seq;
    run_seq(0, 0, "R8");
    for (int k = 0; k < N; k++)
      chk(child_mode_o[k*5 +: 5] == oh(ccode[k]), "R8 child mode", child_mode_o[k*5 +: 5], oh(ccode[k]));
    chk(local_mode_o == oh(2), "R8 local mode", local_mode_o, oh(2));

    // R6 full length
    run_seq(1, p, "R6 full length");

    // drop enable, then R7 stray bits stay out of children
    n = 0;
    for (int k = N - 1; k >= 0; k--) push(ccode[k], MW);
    push(0, MW); push(0, 1);
    run_seq(0, 0, "R7");
    chk(child_en_o == 0, "R4 enable clear", child_en_o, 0);
    n = 0; push(63, 6); push(2, MW); push(0, 1);
    run_seq(0, 0, "R7");
    chk(local_mode_o == oh(2), "R7 local", local_mode_o, oh(2));
    for (int k = 0; k < N; k++)
      chk(child_mode_o[k*5 +: 5] == oh(ccode[k]), "R7 child frozen", child_mode_o[k*5 +: 5], oh(ccode[k]));

    do_reset("R1 mid-run reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule